// File: doc/BRIEF.md
# I2C Controller Interrupt and Status Unit

This unit gathers the event pulses from an I2C master's bus engine, together with the fill levels of its transmit and receive FIFOs (16 entries each by default), into one 12-bit raw status vector. A mask register selects which status bits drive the single interrupt line. Most status bits are sticky and stay set until software reads a clear location. The bus interface signals such a read to this unit as a one-cycle clear code. Two status bits are live level comparisons against programmable FIFO thresholds, and the hardware updates them itself.

A transmit abort starts a two-state machine. In state ABT_IDLE the TX FIFO works normally. The transition T_ABORT is taken on an abort pulse, and it enters ABT_HOLD. In ABT_HOLD the unit asserts `tx_flush`, refuses every TX write, and accumulates the abort cause into an abort-source word. The transition T_RELEASE is taken on a TX-abort clear or a clear-all, provided no new abort arrives in the same cycle. It returns the machine to ABT_IDLE and zeroes the abort source. The unit also keeps a registered six-bit FIFO and bus status word.

Top module: `irq_status_unit`

## Requirements
- R1: Raw status bit positions are RX_UNDER 0, RX_OVER 1, RX_FULL 2, TX_OVER 3, TX_EMPTY 4, TX_ABRT 6, ACTIVITY 8, STOP_DET 9, START_DET 10 and GEN_CALL 11. Bits 5 and 7 read as zero.
- R2: The mask resets to 0x8FF and loads `mask_wdata` when `mask_we` is high. `masked_stat` is raw AND mask, and `irq` is the OR of all bits of `masked_stat`.
- R3: TX_EMPTY is high while the TX level is at or below the effective TX threshold. RX_FULL is high while the RX level is at or above the effective RX threshold. Both thresholds reset to 0. A programmed threshold above 15 acts as 16.
- R4: RX_OVER, ACTIVITY, STOP_DET, START_DET and GEN_CALL are set one cycle after their input pulse, and they stay set until they are cleared.
- R5: `rd_clr` carries a clear code. The codes are 0 none, 1 all, 2 RX_UNDER, 3 RX_OVER, 4 TX_OVER, 5 TX_ABRT, 6 ACTIVITY, 7 STOP_DET, 8 START_DET and 9 GEN_CALL. A specific code clears only its own bit at the next edge.
- R6: Clear code 1 clears every sticky bit, TX_ABRT included, and zeroes `abort_src`.
- R7: When a set event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: An `ev_abort` pulse sets TX_ABRT and `tx_flush` and ORs `abort_cause` into `abort_src`. Both bits hold until code 5 or code 1 arrives without a new abort, and that clear also zeroes `abort_src`.
- R9: While `bus_busy` is high, neither code 6 nor code 1 clears ACTIVITY.
- R10: TX_OVER is set when `tx_wr_req` arrives while the TX level is 16. RX_UNDER is set when `rx_rd_req` arrives while the RX level is 0.
- R11: `status_word` is registered one cycle from its inputs and resets to 0x6. Its layout is bus busy 0, TX not full 1, TX empty 2, RX not empty 3, RX full 4 and controller busy 5.
- R12: `tx_wr_accept` is high only when `tx_wr_req` is high, the unit is not flushing, and the TX level is below 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_over | input | 1 | RX data lost pulse |
| ev_abort | input | 1 | Transmit abort pulse |
| abort_cause | input | 17 | Cause bits that come with an abort |
| ev_activity | input | 1 | Bus activity pulse |
| ev_stop | input | 1 | STOP seen pulse |
| ev_start | input | 1 | START or RESTART seen pulse |
| ev_gen_call | input | 1 | General call acknowledged pulse |
| tx_wr_req | input | 1 | Software write into the TX FIFO |
| rx_rd_req | input | 1 | Software read from the RX FIFO |
| tx_level | input | 5 | TX FIFO fill level, 0 to 16 |
| rx_level | input | 5 | RX FIFO fill level, 0 to 16 |
| bus_busy | input | 1 | I2C bus active |
| ctrl_busy | input | 1 | Controller state machine active |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 12 | New mask value |
| txthr_we | input | 1 | TX threshold load strobe |
| rxthr_we | input | 1 | RX threshold load strobe |
| thr_wdata | input | 8 | New threshold value |
| rd_clr | input | 4 | Clear code from a register read |
| raw_stat | output | 12 | Raw status vector |
| masked_stat | output | 12 | Raw status ANDed with the mask |
| irq | output | 1 | Combined interrupt |
| status_word | output | 6 | Registered FIFO and bus status |
| abort_src | output | 17 | Accumulated abort cause |
| tx_flush | output | 1 | Hold the TX FIFO empty |
| tx_wr_accept | output | 1 | TX write may be stored |

## Verification
A set event and a clear read can hit the same status bit in the same cycle. The abort pulse meeting the TX-abort clear is the most critical case of this, because it decides whether the FIFO leaves flush. The random stimulus fires event pulses and clear codes independently, so such collisions happen often, and a directed sequence places an abort on the same cycle as code 5 and then code 5 alone. A bench model judges each cycle: the bit must still be set, and the abort source must be holding only the new cause.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int STAT_W = 12;

    localparam int B_RX_UNDER = 0;
    localparam int B_RX_OVER  = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_OVER  = 3;
    localparam int B_TX_EMPTY = 4;
    localparam int B_TX_ABRT  = 6;
    localparam int B_ACTIVITY = 8;
    localparam int B_STOP     = 9;
    localparam int B_START    = 10;
    localparam int B_GEN_CALL = 11;

    // bits kept in the sticky bank (TX_ABRT lives in the abort FSM)
    localparam logic [STAT_W-1:0] STICKY_BITS = 12'hF0B;
    localparam logic [STAT_W-1:0] MASK_RST    = 12'h8FF;

    typedef enum logic [3:0] {
        CLR_NONE     = 4'd0,
        CLR_ALL      = 4'd1,
        CLR_RX_UNDER = 4'd2,
        CLR_RX_OVER  = 4'd3,
        CLR_TX_OVER  = 4'd4,
        CLR_TX_ABRT  = 4'd5,
        CLR_ACTIVITY = 4'd6,
        CLR_STOP     = 4'd7,
        CLR_START    = 4'd8,
        CLR_GEN_CALL = 4'd9
    } clr_code_e;

    typedef enum logic {
        ABT_IDLE = 1'b0,
        ABT_HOLD = 1'b1
    } abt_state_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int                N        = 12,
    parameter logic [N-1:0]      KEEP     = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (KEEP[i]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else
                    q[i] <= set_vec[i] | (q[i] & ~clr_vec[i]);
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_abort_fsm.sv
module irq_abort_fsm
    import irq_status_pkg::*;
#(
    parameter int ABW = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           abort_ev,
    input  logic [ABW-1:0] abort_cause,
    input  logic           release_req,
    output logic           flush,
    output logic [ABW-1:0] abort_src
);
    abt_state_e state_q, state_d;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ABT_IDLE: if (abort_ev) state_d = ABT_HOLD;                   // T_ABORT
            ABT_HOLD: if (release_req && !abort_ev) state_d = ABT_IDLE;  // T_RELEASE
            default:  state_d = ABT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ABT_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ABT_HOLD: flush = 1'b1;
            default:  flush = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            abort_src <= '0;
        else if (abort_ev)
            abort_src <= (release_req ? '0 : abort_src) | abort_cause;
        else if (release_req)
            abort_src <= '0;
    end
endmodule

// File: rtl/irq_fifo_levels.sv
module irq_fifo_levels #(
    parameter int DEPTH = 16,
    parameter int THR_W = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] tx_level,
    input  logic [LVLW-1:0] rx_level,
    input  logic            txthr_we,
    input  logic            rxthr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic            bus_busy,
    input  logic            ctrl_busy,
    output logic            tx_below,
    output logic            rx_above,
    output logic            tx_full,
    output logic            rx_empty,
    output logic [5:0]      status_word
);
    localparam logic [THR_W-1:0] THR_TOP  = THR_W'(DEPTH - 1);
    localparam logic [LVLW-1:0]  LVL_FULL = LVLW'(DEPTH);

    logic [THR_W-1:0] tx_thr_q, rx_thr_q;
    logic [LVLW-1:0]  tx_thr_eff, rx_thr_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else begin
            if (txthr_we) tx_thr_q <= thr_wdata;
            if (rxthr_we) rx_thr_q <= thr_wdata;
        end
    end

    assign tx_thr_eff = (tx_thr_q > THR_TOP) ? LVL_FULL : tx_thr_q[LVLW-1:0];
    assign rx_thr_eff = (rx_thr_q > THR_TOP) ? LVL_FULL : rx_thr_q[LVLW-1:0];

    assign tx_below = (tx_level <= tx_thr_eff);
    assign rx_above = (rx_level >= rx_thr_eff);
    assign tx_full  = (tx_level >= LVL_FULL);
    assign rx_empty = (rx_level == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_word <= 6'h06;
        else
            status_word <= {ctrl_busy, (rx_level >= LVL_FULL), !rx_empty,
                            (tx_level == '0), !tx_full, bus_busy};
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int THR_W = 8,
    parameter int ABW   = 17,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_over,
    input  logic              ev_abort,
    input  logic [ABW-1:0]    abort_cause,
    input  logic              ev_activity,
    input  logic              ev_stop,
    input  logic              ev_start,
    input  logic              ev_gen_call,
    input  logic              tx_wr_req,
    input  logic              rx_rd_req,
    input  logic [LVLW-1:0]   tx_level,
    input  logic [LVLW-1:0]   rx_level,
    input  logic              bus_busy,
    input  logic              ctrl_busy,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              txthr_we,
    input  logic              rxthr_we,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic [3:0]        rd_clr,
    output logic [STAT_W-1:0] raw_stat,
    output logic [STAT_W-1:0] masked_stat,
    output logic              irq,
    output logic [5:0]        status_word,
    output logic [ABW-1:0]    abort_src,
    output logic              tx_flush,
    output logic              tx_wr_accept
);
    clr_code_e         code;
    logic              clr_all;
    logic [STAT_W-1:0] set_vec, clr_vec, sticky_q;
    logic [STAT_W-1:0] mask_q;
    logic              tx_below, rx_above, tx_full, rx_empty;
    logic              release_req;

    assign code    = clr_code_e'(rd_clr);
    assign clr_all = (code == CLR_ALL);

    always_comb begin
        set_vec = '0;
        set_vec[B_RX_UNDER] = rx_rd_req & rx_empty;
        set_vec[B_RX_OVER]  = ev_rx_over;
        set_vec[B_TX_OVER]  = tx_wr_req & tx_full;
        set_vec[B_ACTIVITY] = ev_activity;
        set_vec[B_STOP]     = ev_stop;
        set_vec[B_START]    = ev_start;
        set_vec[B_GEN_CALL] = ev_gen_call;

        clr_vec = '0;
        clr_vec[B_RX_UNDER] = clr_all | (code == CLR_RX_UNDER);
        clr_vec[B_RX_OVER]  = clr_all | (code == CLR_RX_OVER);
        clr_vec[B_TX_OVER]  = clr_all | (code == CLR_TX_OVER);
        clr_vec[B_ACTIVITY] = (clr_all | (code == CLR_ACTIVITY)) & ~bus_busy;
        clr_vec[B_STOP]     = clr_all | (code == CLR_STOP);
        clr_vec[B_START]    = clr_all | (code == CLR_START);
        clr_vec[B_GEN_CALL] = clr_all | (code == CLR_GEN_CALL);
    end

    assign release_req = clr_all | (code == CLR_TX_ABRT);

    irq_sticky_bank #(.N(STAT_W), .KEEP(STICKY_BITS)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (sticky_q)
    );

    irq_abort_fsm #(.ABW(ABW)) u_abort (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort_ev    (ev_abort),
        .abort_cause (abort_cause),
        .release_req (release_req),
        .flush       (tx_flush),
        .abort_src   (abort_src)
    );

    irq_fifo_levels #(.DEPTH(DEPTH), .THR_W(THR_W)) u_levels (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .txthr_we    (txthr_we),
        .rxthr_we    (rxthr_we),
        .thr_wdata   (thr_wdata),
        .bus_busy    (bus_busy),
        .ctrl_busy   (ctrl_busy),
        .tx_below    (tx_below),
        .rx_above    (rx_above),
        .tx_full     (tx_full),
        .rx_empty    (rx_empty),
        .status_word (status_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= MASK_RST;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_comb begin
        raw_stat             = sticky_q;
        raw_stat[B_RX_FULL]  = rx_above;
        raw_stat[B_TX_EMPTY] = tx_below;
        raw_stat[B_TX_ABRT]  = tx_flush;
    end

    assign masked_stat  = raw_stat & mask_q;
    assign irq          = |masked_stat;
    assign tx_wr_accept = tx_wr_req & ~tx_flush & ~tx_full;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_abort,
    input logic        ev_stop,
    input logic [3:0]  rd_clr,
    input logic        bus_busy,
    input logic [11:0] raw_stat,
    input logic [11:0] masked_stat,
    input logic        irq,
    input logic        tx_flush,
    input logic        tx_wr_accept
);
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat == 12'h000) |-> !irq);                              // R2
    AST_STOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr == 4'd7 && !ev_stop) |=> !raw_stat[9]);                  // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> raw_stat[9]);                                        // R7
    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> (tx_flush && raw_stat[6]));                         // R8
    AST_ACTIVITY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[8] && bus_busy) |=> raw_stat[8]);                      // R9
    AST_NO_WRITE_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> !tx_wr_accept);                                     // R12
endmodule

bind irq_status_unit irq_status_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_abort     (ev_abort),
    .ev_stop      (ev_stop),
    .rd_clr       (rd_clr),
    .bus_busy     (bus_busy),
    .raw_stat     (raw_stat),
    .masked_stat  (masked_stat),
    .irq          (irq),
    .tx_flush     (tx_flush),
    .tx_wr_accept (tx_wr_accept)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx_over = 0, ev_abort = 0, ev_activity = 0;
    logic        ev_stop = 0, ev_start = 0, ev_gen_call = 0;
    logic [16:0] abort_cause = '0;
    logic        tx_wr_req = 0, rx_rd_req = 0;
    logic [4:0]  tx_level = '0, rx_level = '0;
    logic        bus_busy = 0, ctrl_busy = 0;
    logic        mask_we = 0, txthr_we = 0, rxthr_we = 0;
    logic [11:0] mask_wdata = '0;
    logic [7:0]  thr_wdata = '0;
    logic [3:0]  rd_clr = '0;
    logic [11:0] raw_stat, masked_stat;
    logic        irq, tx_flush, tx_wr_accept;
    logic [5:0]  status_word;
    logic [16:0] abort_src;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    logic [11:0] m_sticky;
    logic        m_hold;
    logic [16:0] m_src;
    logic [11:0] m_mask;
    logic [7:0]  m_txthr, m_rxthr;
    logic [5:0]  m_sw;

    always #4 clk = ~clk;   // 125 MHz

    irq_status_unit dut_i (.*);

    function automatic int eff_thr(input logic [7:0] t);
        return (t > 8'd15) ? 16 : int'(t);
    endfunction

    function automatic logic [11:0] exp_raw();
        logic [11:0] r;
        r = m_sticky;
        r[2] = (int'(rx_level) >= eff_thr(m_rxthr));
        r[4] = (int'(tx_level) <= eff_thr(m_txthr));
        r[6] = m_hold;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sticky = '0; m_hold = 0; m_src = '0; m_mask = 12'h8FF;
        m_txthr = '0; m_rxthr = '0; m_sw = 6'h06;
    endtask

    // called just after inputs are driven at a negedge
    task automatic step();
        logic [11:0] er, setv, clrv;
        logic        rel;
        #1;
        er = exp_raw();
        check("R1 R3 R4 R10 raw_stat", 32'(raw_stat), 32'(er));
        check("R2 masked_stat", 32'(masked_stat), 32'(er & m_mask));
        check("R2 irq", 32'(irq), 32'(|(er & m_mask)));
        check("R8 tx_flush", 32'(tx_flush), 32'(m_hold));
        check("R6 R8 abort_src", 32'(abort_src), 32'(m_src));
        check("R11 status_word", 32'(status_word), 32'(m_sw));
        check("R12 tx_wr_accept", 32'(tx_wr_accept),
              32'(tx_wr_req && !m_hold && tx_level < 5'd16));
        // model of the next edge
        setv = '0;
        setv[0]  = rx_rd_req && rx_level == 0;
        setv[1]  = ev_rx_over;
        setv[3]  = tx_wr_req && tx_level == 5'd16;
        setv[8]  = ev_activity;
        setv[9]  = ev_stop;
        setv[10] = ev_start;
        setv[11] = ev_gen_call;
        clrv = '0;
        clrv[0]  = rd_clr == 1 || rd_clr == 2;
        clrv[1]  = rd_clr == 1 || rd_clr == 3;
        clrv[3]  = rd_clr == 1 || rd_clr == 4;
        clrv[8]  = (rd_clr == 1 || rd_clr == 6) && !bus_busy;
        clrv[9]  = rd_clr == 1 || rd_clr == 7;
        clrv[10] = rd_clr == 1 || rd_clr == 8;
        clrv[11] = rd_clr == 1 || rd_clr == 9;
        rel = (rd_clr == 1 || rd_clr == 5);
        m_sticky = setv | (m_sticky & ~clrv);
        m_src    = (rel ? 17'h0 : m_src) | (ev_abort ? abort_cause : 17'h0);
        m_hold   = ev_abort ? 1'b1 : (rel ? 1'b0 : m_hold);
        if (mask_we)  m_mask  = mask_wdata;
        if (txthr_we) m_txthr = thr_wdata;
        if (rxthr_we) m_rxthr = thr_wdata;
        m_sw = {ctrl_busy, rx_level == 16, rx_level != 0, tx_level == 0,
                tx_level != 16, bus_busy};
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ev_rx_over = 0; ev_abort = 0; ev_activity = 0; ev_stop = 0;
        ev_start = 0; ev_gen_call = 0; abort_cause = '0;
        tx_wr_req = 0; rx_rd_req = 0; mask_we = 0; txthr_we = 0;
        rxthr_we = 0; rd_clr = 4'd0;
    endtask

    task automatic rand_inputs();
        ev_rx_over  = ($urandom % 8) == 0;
        ev_abort    = ($urandom % 16) == 0;
        abort_cause = 17'($urandom);
        ev_activity = ($urandom % 6) == 0;
        ev_stop     = ($urandom % 6) == 0;
        ev_start    = ($urandom % 6) == 0;
        ev_gen_call = ($urandom % 10) == 0;
        tx_wr_req   = ($urandom % 3) == 0;
        rx_rd_req   = ($urandom % 3) == 0;
        tx_level    = 5'($urandom % 17);
        rx_level    = 5'($urandom % 17);
        bus_busy    = ($urandom % 2) == 0;
        ctrl_busy   = ($urandom % 2) == 0;
        mask_we     = ($urandom % 25) == 0;
        mask_wdata  = 12'($urandom);
        txthr_we    = ($urandom % 20) == 0;
        rxthr_we    = ($urandom % 20) == 0;
        thr_wdata   = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 20);
        rd_clr      = (($urandom % 2) == 0) ? 4'($urandom % 10) : 4'd0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        // reset state, R2 mask and R11 status reset values
        #1;
        check("R2 mask reset via masked_stat", 32'(masked_stat), 32'h014);
        check("R11 status reset", 32'(status_word), 32'h06);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: all events unmasked by reset except bits 8..10 of ACTIVITY/STOP/START
        ev_activity = 1; ev_stop = 1; ev_start = 1; ev_gen_call = 1; ev_rx_over = 1;
        tx_level = 5'd3; rx_level = 5'd0; rxthr_we = 1; thr_wdata = 8'd4;
        step();
        idle_inputs(); rd_clr = 4'd3;   // R5: clears only RX_OVER
        step();
        idle_inputs();
        step();
        // R7 / R8: abort and its own clear in the same cycle
        ev_abort = 1; abort_cause = 17'h00001;
        step();
        idle_inputs(); ev_abort = 1; abort_cause = 17'h01000; rd_clr = 4'd5;
        step();
        idle_inputs(); tx_wr_req = 1; tx_level = 5'd2;   // R12 write refused while held
        step();
        idle_inputs(); rd_clr = 4'd5;
        step();
        idle_inputs(); tx_wr_req = 1;
        step();
        // R9: ACTIVITY clear while bus busy, then when idle
        idle_inputs(); ev_activity = 1; bus_busy = 1;
        step();
        idle_inputs(); rd_clr = 4'd6;
        step();
        idle_inputs(); rd_clr = 4'd1;
        step();
        idle_inputs(); bus_busy = 0; rd_clr = 4'd6;
        step();
        // R3: threshold above 15 clamps to 16
        idle_inputs(); txthr_we = 1; rxthr_we = 1; thr_wdata = 8'd200;
        step();
        idle_inputs(); tx_level = 5'd16; rx_level = 5'd15;
        step();
        idle_inputs(); rx_level = 5'd16;
        step();
        // R10 overflow and underflow detection
        idle_inputs(); tx_wr_req = 1; rx_rd_req = 1; tx_level = 5'd16; rx_level = 5'd0;
        step();
        idle_inputs();
        step();
        // R6: clear-all with sticky bits and abort pending
        idle_inputs(); ev_abort = 1; abort_cause = 17'h10000; ev_stop = 1;
        step();
        idle_inputs(); rd_clr = 4'd1;
        step();
        idle_inputs();
        step();
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            step();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule